// File: doc/BRIEF.md
# Debug Entry Handshake Controller

This block runs in the test clock domain and takes a processor core into debug mode when an external active-low debug event line falls. The event line is sampled only while the debug enable input is high. A new event raises a request to the core. When the core reports that it is in debug mode, the block drives an acknowledge enable for a fixed number of test clock periods. That enable can turn on an open-drain pulldown on a shared bidirectional debug pin. It also works as a plain two-wire handshake when no shared pin exists.

The block also keeps an active-low session flag for peripherals. The flag falls the first time the core enters debug state. It stays low while the debugger single-steps the core in and out of debug state. It rises again only when the debugger writes a command that resumes the core for good: both the GO and EX bits set, and a register select code of either "no register" or the CPU scan-control register.

The handshake is a three-state machine. IDLE waits for an event. REQ holds the request until the core confirms. ACK holds the acknowledge for the programmed count. The named transitions are: IDLE to REQ on a synchronized falling edge of the event line; REQ to ACK when the core-in-debug status is seen high; ACK to IDLE when the count expires; and any state to IDLE whenever the enable is sampled low.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While reset is asserted and on release, `dbg_req` and `ack_en` are low and `session_n` is high.
- R2: A rising edge that samples `dbg_en` low returns the handshake to IDLE, so `dbg_req` and `ack_en` are low after that edge. A falling `evt_n` while disabled never produces a request, and a request or acknowledge in progress is abandoned.
- R3: With `dbg_en` high, a falling edge on `evt_n` passes through a two-flop synchronizer and an edge detector. `dbg_req` then goes high after the third rising clock edge that follows the fall. An `evt_n` held low yields one request only. An `evt_n` that is already low when `dbg_en` rises yields no request.
- R4: `dbg_req` stays high until a rising edge samples `core_in_dbg` high. At that edge it falls, and `ack_en` rises at the same edge.
- R5: `ack_en` stays high for exactly three clock periods (parameter `ACK_CYCLES`, default 3) and then falls. The machine then returns to IDLE.
- R6: A falling `evt_n` that arrives while the acknowledge is running neither restarts nor lengthens it, and raises no later request.
- R7: `session_n` goes low after a rising edge that samples `core_in_dbg` high when it was low at the previous edge.
- R8: Once low, `session_n` stays low while `core_in_dbg` toggles, for example during single-stepping.
- R9: `session_n` goes high after a rising edge where `cmd_wr`, `cmd_go` and `cmd_ex` are all 1 and `cmd_rsel` is 7'h7F (no register) or 7'h10 (CPU scan-control register).
- R10: A command with `cmd_go` or `cmd_ex` clear, a command with any other `cmd_rsel`, or command fields presented without `cmd_wr` leaves `session_n` unchanged.
- R11: When a debug-state entry under R7 and a release command under R9 fall on the same edge, the entry wins and `session_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug enable; gates event sampling and the handshake |
| evt_n | input | 1 | Active-low external debug event (asynchronous) |
| core_in_dbg | input | 1 | Core reports that it is in debug state |
| cmd_wr | input | 1 | Debug command register write strobe |
| cmd_go | input | 1 | GO bit of the written command |
| cmd_ex | input | 1 | EX bit of the written command |
| cmd_rsel | input | 7 | Register select code of the written command |
| dbg_req | output | 1 | Request to the core to enter debug mode |
| ack_en | output | 1 | Acknowledge enable, for example for an open-drain pulldown |
| session_n | output | 1 | Active-low debug-session-in-progress flag |

## Verification
Each result has a fixed latency. The request appears three rising edges after the event line falls. The acknowledge rises at the edge that samples the core status and lasts three periods. The session flag responds one edge after a core entry or a command write. The enable takes effect at the next edge. The bench drives every stimulus on a falling clock edge and queues the expected triple of outputs at an exact future cycle count. The monitor compares only at the falling edge of that cycle, so every check lands in the period after the register that produces the result has updated.

// File: rtl/dbg_hs_pkg.sv
package dbg_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2
    } hs_state_t;

    localparam int unsigned DEF_SEL_W = 7;
    localparam logic [DEF_SEL_W-1:0] DEF_SEL_NONE = 7'h7F;
    localparam logic [DEF_SEL_W-1:0] DEF_SEL_SCR  = 7'h10;

endpackage

// File: rtl/dbg_evt_sync.sv
module dbg_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic evt_n,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= 1'b1;
                end else begin
                    chain <= evt_n;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], evt_n};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else begin
            last_q <= chain[STAGES-1];
        end
    end

    // high-to-low transition of the synchronized level, only while enabled
    assign fall = en & last_q & ~chain[STAGES-1];

endmodule

// File: rtl/dbg_ack_timer.sv
module dbg_ack_timer #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] START = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dbg_session_trk.sv
module dbg_session_trk #(
    parameter int                SEL_W    = 7,
    parameter logic [SEL_W-1:0]  SEL_NONE = 7'h7F,
    parameter logic [SEL_W-1:0]  SEL_SCR  = 7'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_in_dbg,
    input  logic             cmd_wr,
    input  logic             cmd_go,
    input  logic             cmd_ex,
    input  logic [SEL_W-1:0] cmd_rsel,
    output logic             session_n
);

    logic core_q;
    logic entry;
    logic resume;

    assign entry  = core_in_dbg & ~core_q;
    assign resume = cmd_wr & cmd_go & cmd_ex &
                    ((cmd_rsel == SEL_NONE) | (cmd_rsel == SEL_SCR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q    <= 1'b0;
            session_n <= 1'b1;
        end else begin
            core_q <= core_in_dbg;
            if (entry) begin
                session_n <= 1'b0;      // entry outranks a resume on the same edge
            end else if (resume) begin
                session_n <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_hs_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                ACK_CYCLES  = 3,
    parameter int                SEL_W       = DEF_SEL_W,
    parameter logic [SEL_W-1:0]  SEL_NONE    = DEF_SEL_NONE,
    parameter logic [SEL_W-1:0]  SEL_SCR     = DEF_SEL_SCR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             evt_n,
    input  logic             core_in_dbg,
    input  logic             cmd_wr,
    input  logic             cmd_go,
    input  logic             cmd_ex,
    input  logic [SEL_W-1:0] cmd_rsel,
    output logic             dbg_req,
    output logic             ack_en,
    output logic             session_n
);

    hs_state_t state_q, state_d;
    logic      evt_fall;
    logic      ack_last;
    logic      ack_load;
    logic      ack_run;

    dbg_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (dbg_en),
        .evt_n (evt_n),
        .fall  (evt_fall)
    );

    dbg_ack_timer #(.CYCLES(ACK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ack_load),
        .run   (ack_run),
        .last  (ack_last)
    );

    dbg_session_trk #(
        .SEL_W    (SEL_W),
        .SEL_NONE (SEL_NONE),
        .SEL_SCR  (SEL_SCR)
    ) u_session (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_in_dbg (core_in_dbg),
        .cmd_wr      (cmd_wr),
        .cmd_go      (cmd_go),
        .cmd_ex      (cmd_ex),
        .cmd_rsel    (cmd_rsel),
        .session_n   (session_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!dbg_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (evt_fall)    state_d = ST_REQ;
                ST_REQ:  if (core_in_dbg) state_d = ST_ACK;
                ST_ACK:  if (ack_last)    state_d = ST_IDLE;
                default:                  state_d = ST_IDLE;
            endcase
        end
    end

    assign ack_load = (state_q == ST_REQ) && (state_d == ST_ACK);
    assign ack_run  = (state_q == ST_ACK);

    // outputs
    always_comb begin
        dbg_req = 1'b0;
        ack_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  dbg_req = 1'b1;
            ST_ACK:  ack_en  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
    parameter int                SEL_W    = 7,
    parameter logic [SEL_W-1:0]  SEL_NONE = 7'h7F,
    parameter logic [SEL_W-1:0]  SEL_SCR  = 7'h10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_en,
    input logic             core_in_dbg,
    input logic             cmd_wr,
    input logic             cmd_go,
    input logic             cmd_ex,
    input logic [SEL_W-1:0] cmd_rsel,
    input logic             dbg_req,
    input logic             ack_en,
    input logic             session_n
);

    logic rel_cmd;
    assign rel_cmd = cmd_wr && cmd_go && cmd_ex &&
                     (cmd_rsel == SEL_NONE || cmd_rsel == SEL_SCR);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!dbg_req && !ack_en && session_n));

    a_r2_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |=> (!dbg_req && !ack_en));

    a_r3_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_req) |-> $past(dbg_en));

    a_r4_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_en) |-> ($past(dbg_req) && $past(core_in_dbg)));

    a_r5_ack_max_len: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && $past(ack_en) && $past(ack_en, 2)) |=> !ack_en);

    a_r5_ack_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_en) && dbg_en) |=> ack_en);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_req && ack_en));

    a_r7_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (core_in_dbg && !$past(core_in_dbg)) |=> !session_n);

    a_r8_session_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!session_n && !rel_cmd) |=> !session_n);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_cmd && !core_in_dbg) |=> session_n);

    a_r10_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (session_n && !core_in_dbg) |=> session_n);

endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(
    .SEL_W    (SEL_W),
    .SEL_NONE (SEL_NONE),
    .SEL_SCR  (SEL_SCR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_en      (dbg_en),
    .core_in_dbg (core_in_dbg),
    .cmd_wr      (cmd_wr),
    .cmd_go      (cmd_go),
    .cmd_ex      (cmd_ex),
    .cmd_rsel    (cmd_rsel),
    .dbg_req     (dbg_req),
    .ack_en      (ack_en),
    .session_n   (session_n)
);

// File: tb/dbg_entry_ctrl_test.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dbg_en;
    logic       evt_n;
    logic       core_in_dbg;
    logic       cmd_wr;
    logic       cmd_go;
    logic       cmd_ex;
    logic [6:0] cmd_rsel;
    logic       dbg_req;
    logic       ack_en;
    logic       session_n;

    int cyc   = 0;
    int total = 0;
    int bad   = 0;

    typedef struct {
        int    at;
        logic  r;
        logic  a;
        logic  s;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    dbg_entry_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_en      (dbg_en),
        .evt_n       (evt_n),
        .core_in_dbg (core_in_dbg),
        .cmd_wr      (cmd_wr),
        .cmd_go      (cmd_go),
        .cmd_ex      (cmd_ex),
        .cmd_rsel    (cmd_rsel),
        .dbg_req     (dbg_req),
        .ack_en      (ack_en),
        .session_n   (session_n)
    );

    // driver side: queue expected {req, ack, session_n} at cyc + dly
    task automatic expect_at(input int dly, input logic r, input logic a,
                             input logic s, input string tag);
        exp_t e;
        e.at = cyc + dly; e.r = r; e.a = a; e.s = s; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic go, input logic ex, input logic [6:0] sel);
        cmd_wr = 1'b1; cmd_go = go; cmd_ex = ex; cmd_rsel = sel;
        tick(1);
        cmd_wr = 1'b0; cmd_go = 1'b0; cmd_ex = 1'b0; cmd_rsel = 7'h00;
    endtask

    // monitor side
    always @(negedge clk) begin
        automatic exp_t keep[$];
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at == cyc) begin
                total++;
                if (dbg_req !== sb[i].r || ack_en !== sb[i].a || session_n !== sb[i].s) begin
                    bad++;
                    $display("FAIL %s cyc=%0d actual req/ack/sess=%b%b%b expected=%b%b%b",
                             sb[i].tag, cyc, dbg_req, ack_en, session_n,
                             sb[i].r, sb[i].a, sb[i].s);
                end
            end else begin
                keep.push_back(sb[i]);
            end
        end
        sb = keep;
    end

    always @(posedge clk) begin
        if (cyc > 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dbg_en = 1'b0; evt_n = 1'b1; core_in_dbg = 1'b0;
        cmd_wr = 1'b0; cmd_go = 1'b0; cmd_ex = 1'b0; cmd_rsel = 7'h00;
        expect_at(1, 0, 0, 1, "R1 in reset");
        tick(3);
        rst_n = 1'b1;
        expect_at(1, 0, 0, 1, "R1 after release");
        dbg_en = 1'b1;
        tick(3);

        // R3 basic entry, R4 wait, R5 ack, R7 session
        evt_n = 1'b0;
        expect_at(2, 0, 0, 1, "R3 sync latency");
        expect_at(3, 1, 0, 1, "R3 request");
        tick(3);
        expect_at(2, 1, 0, 1, "R4 request held");
        tick(3);
        core_in_dbg = 1'b1;
        expect_at(1, 0, 1, 0, "R4/R5/R7 ack start");
        expect_at(2, 0, 1, 0, "R5 ack 2");
        expect_at(3, 0, 1, 0, "R5 ack 3");
        expect_at(4, 0, 0, 0, "R5 ack end");
        expect_at(7, 0, 0, 0, "R3 held low single request");
        tick(8);

        // R8 single steps
        core_in_dbg = 1'b0;
        expect_at(1, 0, 0, 0, "R8 exit");
        tick(2);
        core_in_dbg = 1'b1;
        expect_at(1, 0, 0, 0, "R8 re-entry");
        tick(2);
        core_in_dbg = 1'b0;
        evt_n = 1'b1;
        tick(3);

        // R10 non-release commands
        expect_at(1, 0, 0, 0, "R10 go only");
        send_cmd(1'b1, 1'b0, 7'h7F);
        expect_at(1, 0, 0, 0, "R10 other select");
        send_cmd(1'b1, 1'b1, 7'h05);
        expect_at(1, 0, 0, 0, "R10 ex only");
        send_cmd(1'b0, 1'b1, 7'h10);
        cmd_go = 1'b1; cmd_ex = 1'b1; cmd_rsel = 7'h7F;
        expect_at(1, 0, 0, 0, "R10 no strobe");
        tick(1);
        cmd_go = 1'b0; cmd_ex = 1'b0; cmd_rsel = 7'h00;

        // R9 release with both codes, R7 re-entry
        expect_at(1, 0, 0, 1, "R9 no-register code");
        send_cmd(1'b1, 1'b1, 7'h7F);
        core_in_dbg = 1'b1;
        expect_at(1, 0, 0, 0, "R7 new session");
        tick(1);
        core_in_dbg = 1'b0;
        tick(1);
        expect_at(1, 0, 0, 1, "R9 scan-control code");
        send_cmd(1'b1, 1'b1, 7'h10);

        // R11 entry and release on the same edge
        core_in_dbg = 1'b1;
        expect_at(1, 0, 0, 0, "R11 entry wins");
        send_cmd(1'b1, 1'b1, 7'h7F);
        core_in_dbg = 1'b0;
        tick(1);
        expect_at(1, 0, 0, 1, "R9 release after R11");
        send_cmd(1'b1, 1'b1, 7'h7F);

        // R2 disabled event ignored
        dbg_en = 1'b0;
        evt_n = 1'b0;
        expect_at(3, 0, 0, 1, "R2 ignored while disabled");
        expect_at(5, 0, 0, 1, "R2 ignored while disabled");
        tick(5);
        dbg_en = 1'b1;
        expect_at(4, 0, 0, 1, "R3 no edge at enable");
        tick(5);
        evt_n = 1'b1;
        tick(4);
        evt_n = 1'b0;
        expect_at(3, 1, 0, 1, "R3 request after re-enable");
        tick(3);
        dbg_en = 1'b0;
        expect_at(1, 0, 0, 1, "R2 request abandoned");
        expect_at(3, 0, 0, 1, "R2 stays idle");
        tick(3);

        // R2 abandon during acknowledge
        evt_n = 1'b1; dbg_en = 1'b1;
        tick(4);
        evt_n = 1'b0;
        expect_at(3, 1, 0, 1, "R3 request");
        tick(3);
        core_in_dbg = 1'b1;
        expect_at(1, 0, 1, 0, "R5 ack start");
        tick(1);
        dbg_en = 1'b0;
        expect_at(1, 0, 0, 0, "R2 ack abandoned");
        expect_at(2, 0, 0, 0, "R2 ack stays low");
        tick(3);
        core_in_dbg = 1'b0;
        expect_at(1, 0, 0, 1, "R9 release");
        send_cmd(1'b1, 1'b1, 7'h7F);
        dbg_en = 1'b1; evt_n = 1'b1;
        tick(4);

        // R6 event during acknowledge
        evt_n = 1'b0;
        expect_at(3, 1, 0, 1, "R3 request");
        tick(3);
        evt_n = 1'b1;
        tick(2);
        core_in_dbg = 1'b1;
        expect_at(1, 0, 1, 0, "R6 ack 1");
        expect_at(2, 0, 1, 0, "R6 ack 2");
        expect_at(3, 0, 1, 0, "R6 ack 3");
        expect_at(4, 0, 0, 0, "R6 not extended");
        expect_at(5, 0, 0, 0, "R6 event dropped");
        expect_at(7, 0, 0, 0, "R6 event dropped");
        tick(1);
        evt_n = 1'b0;
        tick(8);
        core_in_dbg = 1'b0;
        evt_n = 1'b1;
        tick(3);

        for (int i = 0; i < sb.size(); i++) begin
            total++;
            bad++;
            $display("FAIL %s actual=unchecked expected=checked at cyc %0d", sb[i].tag, sb[i].at);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule